// File: doc/BRIEF.md
# End-of-Write Status Read Path

This block owns the read data bus of a byte-wide non-volatile memory while a self-timed program cycle may be running. When the host performs a read (chip enable and output enable asserted low, write enable high), the block either passes array data straight through or, if the program engine reports busy, returns a status word. A host polls that word to learn when programming has finished.

The status word carries two signals. The top bit is the inverse of the top bit of the last byte loaded by the write controller, so it reads as true data only once programming is done. The bit below it flips on every completed read strobe while busy, so two back-to-back reads differ until the cycle ends. The low bits are driven to zero. When the busy flag drops, reads return array data on all bits and the flipping stops. The bus driver is modelled as an output-enable signal; when it is low the data output is held at zero.

Top module: `eow_status_read`

## Requirements
- R1: `data_oe_o` is 1 in the same cycle that `ce_ni`=0, `oe_ni`=0 and `we_ni`=1, and 0 otherwise (write enable low or either strobe high blocks it).
- R2: Whenever `data_oe_o` is 0, `data_o` is all zeros.
- R3: While `busy_i`=0 and a read is active, `data_o` equals `arr_data_i` on every bit.
- R4: While `busy_i`=1 and a read is active, `data_o[7]` is the complement of bit 7 of the last byte loaded.
- R5: While `busy_i`=1 and a read is active, `data_o[5:0]` is 0 regardless of `arr_data_i`.
- R6: While `busy_i`=1, `data_o[6]` stays constant throughout one read and holds the opposite value in the next read; it advances once per completed read strobe, not per clock.
- R7: A `wr_load_i` pulse captures `wr_data_i` at that clock edge; in a page of several loads, the last one is the reference, and it is held until the next load.
- R8: After `busy_i` falls, reads return `arr_data_i` on all bits, including bits 7 and 6, across repeated reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| busy_i | input | 1 | Program cycle in progress |
| wr_load_i | input | 1 | Byte-load pulse from write controller |
| wr_data_i | input | DATA_W | Byte being loaded |
| arr_data_i | input | DATA_W | Array read data |
| data_o | output | DATA_W | Read data bus |
| data_oe_o | output | 1 | Bus drive enable |

## Verification
The drive enable, pass-through data, polling bit and zero fill are combinational on the strobes and busy flag, so they are due in the same cycle as the stimulus. Inputs change one time unit after a rising edge and outputs are compared at the falling edge. The last-byte reference takes one edge after a load pulse; the bench model captures it at the same edge. The toggle bit is judged relative to the previous read in the same busy period rather than against an absolute value: it is captured at read start, held to that value for the whole strobe, and required to differ at the next strobe.

// File: rtl/eow_status_pkg.sv
package eow_status_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } rd_src_e;
endpackage

// File: rtl/eow_read_decode.sv
module eow_read_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  output logic rd_o,
  output logic rd_done_o
);
  logic rd_q;

  assign rd_o = ~ce_ni & ~oe_ni & we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_o;
  end

  // strobe completes when the active read is released
  assign rd_done_o = rd_q & ~rd_o;
endmodule

// File: rtl/eow_last_byte.sv
module eow_last_byte #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_o <= '0;
    else if (load_i) last_o <= data_i;
  end
endmodule

// File: rtl/eow_toggle.sv
module eow_toggle #(
  parameter logic TOG_INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic rd_done_i,
  output logic tog_o
);
  logic busy_q;
  logic start;

  assign start = busy_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tog_o  <= TOG_INIT;
    end else begin
      busy_q <= busy_i;
      if (start)                  tog_o <= TOG_INIT;
      else if (busy_i && rd_done_i) tog_o <= ~tog_o;
    end
  end
endmodule

// File: rtl/eow_status_read.sv
module eow_status_read
  import eow_status_pkg::*;
#(
  parameter int   DATA_W   = 8,
  parameter logic TOG_INIT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              busy_i,
  input  logic              wr_load_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;
  localparam int FILL_W   = DATA_W - 2;

  logic              rd;
  logic              rd_done;
  logic              tog_q;
  logic [DATA_W-1:0] last_q;
  logic [DATA_W-1:0] status_word;
  rd_src_e           src;

  eow_read_decode i_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .we_ni    (we_ni),
    .rd_o     (rd),
    .rd_done_o(rd_done)
  );

  eow_last_byte #(.DATA_W(DATA_W)) i_last (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(wr_load_i),
    .data_i(wr_data_i),
    .last_o(last_q)
  );

  eow_toggle #(.TOG_INIT(TOG_INIT)) i_tog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy_i),
    .rd_done_i(rd_done),
    .tog_o    (tog_q)
  );

  assign status_word = {~last_q[POLL_BIT], tog_q, {FILL_W{1'b0}}};

  always_comb begin
    if (!rd)        src = SRC_NONE;
    else if (busy_i) src = SRC_STATUS;
    else            src = SRC_ARRAY;
  end

  always_comb begin
    unique case (src)
      SRC_ARRAY:  data_o = arr_data_i;
      SRC_STATUS: data_o = status_word;
      default:    data_o = '0;
    endcase
  end

  assign data_oe_o = (src != SRC_NONE);

  // TOG_BIT documents the status layout for readers of the checker
  logic unused_tog_bit;
  assign unused_tog_bit = status_word[TOG_BIT] ^ tog_q;
endmodule

// File: rtl/eow_status_read_chk.sv
module eow_status_read_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              we_ni,
  input logic              busy_i,
  input logic [DATA_W-1:0] arr_data_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic [DATA_W-1:0] last_q,
  input logic              tog_q
);
  AST_BLOCKED_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni || !we_ni) |-> !data_oe_o); // R1
  AST_RELEASED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0)); // R2
  AST_IDLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && data_oe_o) |-> (data_o == arr_data_i)); // R3
  AST_POLL_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && data_oe_o) |-> (data_o[DATA_W-1] != last_q[DATA_W-1])); // R4
  AST_FILL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && data_oe_o) |-> (data_o[DATA_W-3:0] == '0)); // R5
  AST_TOG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && data_oe_o && $past(data_oe_o))
      |-> $stable(data_o[DATA_W-2])); // R6
  AST_TOG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !$rose(busy_i) && $fell(data_oe_o)) |=> (tog_q != $past(tog_q))); // R6
endmodule

bind eow_status_read eow_status_read_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_ni     (ce_ni),
  .oe_ni     (oe_ni),
  .we_ni     (we_ni),
  .busy_i    (busy_i),
  .arr_data_i(arr_data_i),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .last_q    (last_q),
  .tog_q     (tog_q)
);

// File: tb/test_eow_status_read.sv
module test_eow_status_read;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic          busy = 1'b0, wr_load = 1'b0;
  logic [DW-1:0] wr_data = '0, arr_data = '0;
  logic [DW-1:0] data;
  logic          data_oe;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  eow_status_read i_eow_status_read (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .busy_i(busy), .wr_load_i(wr_load), .wr_data_i(wr_data),
    .arr_data_i(arr_data), .data_o(data), .data_oe_o(data_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model
  logic [DW-1:0] m_last = '0;
  always @(posedge clk) if (rst_n && wr_load) m_last <= wr_data;

  bit   prev_rd = 0, have_prev = 0;
  logic prev_b6 = 0, cur_b6 = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit             exp_oe;
      logic [DW-1:0]  exp_d;
      exp_oe = !ce_n && !oe_n && we_n;
      chk(data_oe == exp_oe, "R1", {7'd0, data_oe}, {7'd0, exp_oe});
      if (!exp_oe) chk(data == '0, "R2", data, '0);
      else if (!busy) chk(data == arr_data, "R3 R8", data, arr_data);
      else begin
        exp_d = {~m_last[7], data[6], 6'd0};
        chk(data[7] == exp_d[7], "R4 R7", data, exp_d);
        chk(data[5:0] == 6'd0, "R5", data, exp_d);
        if (!prev_rd) begin
          if (have_prev) chk(data[6] != prev_b6, "R6 step", {7'd0, data[6]}, {7'd0, ~prev_b6});
          cur_b6 = data[6];
        end else chk(data[6] == cur_b6, "R6 hold", {7'd0, data[6]}, {7'd0, cur_b6});
      end
      if (!busy) have_prev = 0;
      else if (prev_rd && !exp_oe) begin have_prev = 1; prev_b6 = cur_b6; end
      prev_rd = exp_oe;
    end
  end

  task automatic rd(input int len, input logic [DW-1:0] a);
    @(posedge clk); #1 arr_data = a; ce_n = 0; oe_n = 0;
    repeat (len) @(posedge clk);
    #1 ce_n = 1; oe_n = 1;
    @(posedge clk);
  endtask

  task automatic load(input logic [DW-1:0] d);
    @(posedge clk); #1 wr_load = 1; wr_data = d;
    @(posedge clk); #1 wr_load = 0;
  endtask

  task automatic program_cycle(input logic [DW-1:0] last, input int reads);
    load(8'h11); load(8'hE2); load(last);   // R7: page of three, last wins
    @(posedge clk); #1 busy = 1;
    for (int i = 0; i < reads; i++) rd(1 + (i % 3), 8'h5A ^ 8'(i * 37));
    @(posedge clk); #1 busy = 0;
    rd(2, 8'hC3); rd(1, 8'h7F); rd(1, 8'h40); // R8
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    chk(data_oe == 0 && data == '0, "R2 reset", data, '0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(1, 8'hA5); rd(3, 8'h3C); rd(1, 8'hFF); // R3
    @(posedge clk); #1 we_n = 0; ce_n = 0; oe_n = 0; arr_data = 8'h99; // R1 blocked
    @(posedge clk); #1 we_n = 1; ce_n = 1;                              // R1 ce high
    @(posedge clk); #1 oe_n = 1;
    program_cycle(8'h3C, 7);
    program_cycle(8'hA5, 6);
    // R7: load while idle changes reference for next busy period only
    load(8'h80);
    @(posedge clk); #1 busy = 1;
    rd(2, 8'h00); rd(1, 8'hFF);
    @(posedge clk); #1 busy = 0;
    rd(1, 8'h66);
    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule